// File: doc/BRIEF.md
# I2C Master Byte Transfer Engine

This block moves single bytes across an I2C bus as the bus master, once an outside sequencer has already issued the start condition. The CPU side starts a transmit by writing a byte. It starts a receive with a receive command, and it ends a received byte with an acknowledge command. The engine produces the SCL clock from a reload counter. When each byte or acknowledge bit is done, the engine stops and holds SCL low until the CPU issues the next command. Status flags report buffer occupancy, write collisions, receive overruns, the slave's acknowledge and completion.

Both bus lines are open drain. Each line is shown as a drive-low enable, and SDA is also read back as a sampled input level. A bus clock phase, low or high, lasts `reload_val + 1` system clocks. Data goes out MSB first and changes only as a low phase begins. Incoming SDA is sampled once, in the middle of each high phase.

The controller has seven states. In `ST_IDLE`, SCL is held low and SDA is left where it was. A transmit uses `ST_TX_LOW` and `ST_TX_HIGH` for nine clocks: eight data bits and one acknowledge clock. A receive uses `ST_RX_LOW` and `ST_RX_HIGH` for eight clocks. The acknowledge sequence uses `ST_ACK_LOW` and `ST_ACK_HIGH` for one clock. The transitions are as follows:
- IDLE→TX_LOW on a byte write.
- IDLE→RX_LOW on a receive command, if no write arrives in the same cycle.
- IDLE→ACK_LOW on an acknowledge command, if neither of the other two arrives.
- Each LOW state goes to its HIGH state on a baud tick.
- TX_HIGH→TX_LOW on a tick before the ninth clock, and TX_HIGH→IDLE on the tick of the ninth clock.
- RX_HIGH→RX_LOW on a tick before the eighth clock, and RX_HIGH→IDLE on the tick of the eighth clock.
- ACK_HIGH→IDLE on its tick.

Top module: `i2c_byte_master`

## Requirements
- R1: A `tx_wr` pulse in the idle state sets `buf_full`, starts the bus clock with SCL low, and drives SDA with the byte's MSB (`sda_drive_low` = 1 sends a 0).
- R2: Every SCL low phase and every SCL high phase lasts exactly `reload_val + 1` clock cycles. Transmit bits go out MSB first, and SDA changes only at the start of a low phase.
- R3: When the eighth transmit clock falls, `buf_full` clears and SDA is released for the ninth clock.
- R4: `ack_stat` takes the SDA level sampled in the middle of the ninth high phase: 0 when the slave pulled SDA low, 1 when SDA stayed high.
- R5: After its last clock, every operation returns to idle. The counter stops, SCL stays driven low, and SDA keeps its last drive until the next command. After reset, SCL is driven low, SDA is released and all flags are 0.
- R6: A `tx_wr` pulse outside idle sets `wcol` and leaves the byte being sent unchanged. `wcol` stays set until a `clr_wcol` pulse.
- R7: An `rx_start` pulse in idle sets `rx_busy`, releases SDA, and clocks in eight bits MSB first, each sampled in the middle of its high phase.
- R8: When the eighth receive clock falls, `rx_busy` clears, `rx_data` takes the received byte, `buf_full` and `done` are set, and SCL is held low.
- R9: An `rx_rd` pulse clears `buf_full`. If a received byte completes while `buf_full` is still set, `rx_ov` is set and `rx_data` takes the new byte. Only `clr_ov` clears `rx_ov`.
- R10: `rx_start` and `ack_start` have no effect outside idle.
- R11: An `ack_start` pulse in idle makes one bus clock, with SDA driven low when `ack_value` = 0 (ACK) and released when it is 1 (NACK), and then sets `done`.
- R12: `done` is set at the end of every transmit, receive and acknowledge sequence, and only a `clr_done` pulse clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| reload_val | input | DIV_W | Baud reload value; each phase lasts reload_val+1 clocks |
| tx_data | input | DATA_W | Byte to transmit |
| tx_wr | input | 1 | Write pulse for tx_data |
| rx_start | input | 1 | Receive command pulse |
| ack_start | input | 1 | Acknowledge-sequence command pulse |
| ack_value | input | 1 | Bit sent by the acknowledge sequence (0 = ACK) |
| rx_rd | input | 1 | Read pulse for rx_data |
| clr_wcol | input | 1 | Clears wcol |
| clr_ov | input | 1 | Clears rx_ov |
| clr_done | input | 1 | Clears done |
| sda_in | input | 1 | Sampled SDA line level |
| scl_drive_low | output | 1 | Pull SCL low when 1 |
| sda_drive_low | output | 1 | Pull SDA low when 1 |
| rx_data | output | DATA_W | Read buffer |
| buf_full | output | 1 | Buffer full flag |
| wcol | output | 1 | Write collision flag |
| rx_ov | output | 1 | Receive overflow flag |
| ack_stat | output | 1 | Acknowledge status from the slave |
| done | output | 1 | Transfer complete flag |
| rx_busy | output | 1 | Receive enable, cleared when the receive finishes |

## Verification
Several rules are checked by the assertions on every cycle:
- SCL holds its level between baud ticks, and the baud counter steps down by exactly one.
- SDA stays stable through transmit high phases and while idle.
- SDA is released and `buf_full` is clear on the ninth transmit clock.
- `wcol` and `done` stay set until cleared, and `rx_ov` rises only while `buf_full` is set.
- A receive command outside idle never raises `rx_busy`.

Only the scenarios can show the rest:
- Exact phase widths for several reload values.
- The bit order on SDA.
- The captured slave acknowledge and the received bytes.
- The overrun case that overwrites the buffer.
- A collision that leaves the byte in flight unchanged.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_TX_LOW,
        ST_TX_HIGH,
        ST_RX_LOW,
        ST_RX_HIGH,
        ST_ACK_LOW,
        ST_ACK_HIGH
    } phase_e;
endpackage

// File: rtl/i2cm_baud.sv
module i2cm_baud #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] reload,
    output logic             tick,
    output logic             mid
);
    logic [DIV_W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          cnt <= '0;
        else if (!run)       cnt <= reload;
        else if (cnt == '0)  cnt <= reload;
        else                 cnt <= cnt - 1'b1;
    end

    assign tick = run && (cnt == '0);
    assign mid  = run && (cnt == (reload >> 1));

    // R2: within a phase the counter steps down by one each clock
    assert_count_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !tick) |=> (cnt == $past(cnt) - 1'b1));
endmodule

// File: rtl/i2cm_shifter.sv
module i2cm_shifter #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] load_val,
    input  logic              shift,
    input  logic              fill,
    output logic [DATA_W-1:0] q,
    output logic [DATA_W-1:0] nxt
);
    assign nxt = {q[DATA_W-2:0], fill};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     q <= '0;
        else if (load)  q <= load_val;
        else if (shift) q <= nxt;
    end
endmodule

// File: rtl/i2c_byte_master.sv
module i2c_byte_master
    import i2cm_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int DIV_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DIV_W-1:0]  reload_val,
    input  logic [DATA_W-1:0] tx_data,
    input  logic              tx_wr,
    input  logic              rx_start,
    input  logic              ack_start,
    input  logic              ack_value,
    input  logic              rx_rd,
    input  logic              clr_wcol,
    input  logic              clr_ov,
    input  logic              clr_done,
    input  logic              sda_in,
    output logic              scl_drive_low,
    output logic              sda_drive_low,
    output logic [DATA_W-1:0] rx_data,
    output logic              buf_full,
    output logic              wcol,
    output logic              rx_ov,
    output logic              ack_stat,
    output logic              done,
    output logic              rx_busy
);
    localparam int CNT_W = $clog2(DATA_W + 1);
    localparam logic [CNT_W-1:0] TX_ACK_BIT = CNT_W'(DATA_W);
    localparam logic [CNT_W-1:0] TX_LAST    = CNT_W'(DATA_W - 1);
    localparam logic [CNT_W-1:0] RX_LAST    = CNT_W'(DATA_W - 1);

    phase_e            state, nstate;
    logic [CNT_W-1:0]  bitcnt;
    logic              tick, mid, idle, ack_bit;
    logic              tx_go, rx_go, ack_go, tx_step, tx_end, rx_step, rx_end, ack_end, in_tx;
    logic [DATA_W-1:0] sh_q, sh_nxt;

    assign idle    = (state == ST_IDLE);
    assign in_tx   = (state == ST_TX_LOW) || (state == ST_TX_HIGH);
    assign tx_go   = idle && tx_wr;
    assign rx_go   = idle && !tx_wr && rx_start;
    assign ack_go  = idle && !tx_wr && !rx_start && ack_start;
    assign tx_step = (state == ST_TX_HIGH) && tick && (bitcnt != TX_ACK_BIT);
    assign tx_end  = (state == ST_TX_HIGH) && tick && (bitcnt == TX_ACK_BIT);
    assign rx_step = (state == ST_RX_HIGH) && tick && (bitcnt != RX_LAST);
    assign rx_end  = (state == ST_RX_HIGH) && tick && (bitcnt == RX_LAST);
    assign ack_end = (state == ST_ACK_HIGH) && tick;

    i2cm_baud #(.DIV_W(DIV_W)) baud_i (
        .clk(clk), .rst_n(rst_n), .run(!idle), .reload(reload_val),
        .tick(tick), .mid(mid)
    );

    i2cm_shifter #(.DATA_W(DATA_W)) shift_i (
        .clk(clk), .rst_n(rst_n), .load(tx_go), .load_val(tx_data),
        .shift(tx_step || ((state == ST_RX_HIGH) && mid)),
        .fill((state == ST_RX_HIGH) ? sda_in : 1'b0),
        .q(sh_q), .nxt(sh_nxt)
    );

    // next-state logic
    always_comb begin
        nstate = state;
        unique case (state)
            ST_IDLE: begin
                if (tx_wr)          nstate = ST_TX_LOW;
                else if (rx_start)  nstate = ST_RX_LOW;
                else if (ack_start) nstate = ST_ACK_LOW;
            end
            ST_TX_LOW:   if (tick) nstate = ST_TX_HIGH;
            ST_TX_HIGH:  if (tick) nstate = (bitcnt == TX_ACK_BIT) ? ST_IDLE : ST_TX_LOW;
            ST_RX_LOW:   if (tick) nstate = ST_RX_HIGH;
            ST_RX_HIGH:  if (tick) nstate = (bitcnt == RX_LAST) ? ST_IDLE : ST_RX_LOW;
            ST_ACK_LOW:  if (tick) nstate = ST_ACK_HIGH;
            ST_ACK_HIGH: if (tick) nstate = ST_IDLE;
            default:     nstate = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nstate;
    end

    // bus clock output
    always_comb begin
        scl_drive_low = !((state == ST_TX_HIGH) || (state == ST_RX_HIGH) || (state == ST_ACK_HIGH));
    end

    // registered outputs, counters and flags
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bitcnt        <= '0;
            sda_drive_low <= 1'b0;
            ack_bit       <= 1'b1;
            ack_stat      <= 1'b0;
            rx_data       <= '0;
            buf_full      <= 1'b0;
            rx_ov         <= 1'b0;
            wcol          <= 1'b0;
            done          <= 1'b0;
            rx_busy       <= 1'b0;
        end else begin
            if (tx_go || rx_go || ack_go)  bitcnt <= '0;
            else if (tx_step || rx_step)   bitcnt <= bitcnt + 1'b1;

            if (tx_go)        sda_drive_low <= ~tx_data[DATA_W-1];
            else if (tx_step) sda_drive_low <= (bitcnt == TX_LAST) ? 1'b0 : ~sh_nxt[DATA_W-1];
            else if (rx_go)   sda_drive_low <= 1'b0;
            else if (ack_go)  sda_drive_low <= ~ack_value;

            if ((state == ST_TX_HIGH) && mid) ack_bit <= sda_in;
            if (tx_end) ack_stat <= mid ? sda_in : ack_bit;

            if (rx_end) rx_data <= mid ? sh_nxt : sh_q;

            if (tx_go || rx_end)                        buf_full <= 1'b1;
            else if (tx_step && (bitcnt == TX_LAST))    buf_full <= 1'b0;
            else if (rx_rd && !in_tx)                   buf_full <= 1'b0;

            if (rx_end && buf_full) rx_ov <= 1'b1;
            else if (clr_ov)        rx_ov <= 1'b0;

            if (tx_wr && !idle) wcol <= 1'b1;
            else if (clr_wcol)  wcol <= 1'b0;

            if (tx_end || rx_end || ack_end) done <= 1'b1;
            else if (clr_done)               done <= 1'b0;

            if (rx_go)       rx_busy <= 1'b1;
            else if (rx_end) rx_busy <= 1'b0;
        end
    end

    // R2: SCL only moves on a baud tick
    assert_scl_on_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!idle && !tick) |=> $stable(scl_drive_low));
    // R2: SDA is stable while SCL is high during transmit
    assert_tx_high_stable_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_TX_HIGH && $past(state) == ST_TX_HIGH) |-> $stable(sda_drive_low));
    // R3: ninth transmit clock has SDA released and buffer empty
    assert_ack_slot_release_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_TX_LOW && bitcnt == TX_ACK_BIT) |-> (!sda_drive_low && !buf_full));
    // R5: SDA is left untouched while idle
    assert_idle_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (idle && $past(state) == ST_IDLE) |-> ($stable(sda_drive_low) && scl_drive_low));
    // R6: collision flag is sticky
    assert_wcol_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wcol && !clr_wcol) |=> wcol);
    // R9: overflow only arises over a full buffer
    assert_ov_needs_full_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_ov) |-> $past(buf_full));
    // R10: receive command outside idle is ignored
    assert_rx_cmd_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!idle && rx_start && !rx_busy) |=> !rx_busy);
    // R12: completion flag is sticky
    assert_done_sticky_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !clr_done) |=> done);
endmodule

// File: tb/i2c_byte_master_tb_top.sv
`timescale 1ns/1ps
module i2c_byte_master_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] reload_val = 8'd3;
    logic [7:0] tx_data = 8'h00;
    logic       tx_wr = 0, rx_start = 0, ack_start = 0, ack_value = 0, rx_rd = 0;
    logic       clr_wcol = 0, clr_ov = 0, clr_done = 0;
    logic       slave_low = 0;
    logic       sda_in, scl_drive_low, sda_drive_low;
    logic [7:0] rx_data;
    logic       buf_full, wcol, rx_ov, ack_stat, done, rx_busy;
    int         n_vec = 0, n_bad = 0;

    always #2.5 clk = ~clk;
    assign sda_in = !(sda_drive_low || slave_low);

    i2c_byte_master dut_i (
        .clk(clk), .rst_n(rst_n), .reload_val(reload_val), .tx_data(tx_data),
        .tx_wr(tx_wr), .rx_start(rx_start), .ack_start(ack_start), .ack_value(ack_value),
        .rx_rd(rx_rd), .clr_wcol(clr_wcol), .clr_ov(clr_ov), .clr_done(clr_done),
        .sda_in(sda_in), .scl_drive_low(scl_drive_low), .sda_drive_low(sda_drive_low),
        .rx_data(rx_data), .buf_full(buf_full), .wcol(wcol), .rx_ov(rx_ov),
        .ack_stat(ack_stat), .done(done), .rx_busy(rx_busy)
    );

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // count negedges while SCL keeps level lvl; command pulses last one cycle
    task automatic walk(input logic lvl, output int n);
        n = 0;
        while (scl_drive_low === lvl && n < 1000) begin
            n++;
            @(negedge clk);
            tx_wr = 0; rx_start = 0; ack_start = 0;
        end
    endtask

    task automatic pulse_clear(input int which);
        @(negedge clk);
        clr_done = (which == 0); clr_wcol = (which == 1); clr_ov = (which == 2); rx_rd = (which == 3);
        @(negedge clk);
        clr_done = 0; clr_wcol = 0; clr_ov = 0; rx_rd = 0;
    endtask

    task automatic tx_byte(input logic [7:0] r, input logic [7:0] d, input logic acked, input logic inject);
        int n;
        reload_val = r;
        @(negedge clk); tx_wr = 1; tx_data = d;
        @(negedge clk); tx_wr = 0; tx_data = ~d;
        chk("R1", "buf_full after write", buf_full, 1);
        chk("R1", "scl low first phase", scl_drive_low, 1);
        for (int i = 0; i < 9; i++) begin
            chk(i < 8 ? "R2" : "R3", "sda bit", sda_drive_low, i < 8 ? !d[7-i] : 1'b0);
            if (i == 8) chk("R3", "buf_full cleared at ack clock", buf_full, 0);
            if (i == 3 && inject) begin tx_wr = 1; rx_start = 1; ack_start = 1; end
            if (i == 8) slave_low = acked;
            walk(1'b1, n); chk("R2", "low width", n, r + 1);
            walk(1'b0, n); chk("R2", "high width", n, r + 1);
        end
        slave_low = 0;
        chk("R4", "ack_stat", ack_stat, !acked);
        chk("R12", "done after tx", done, 1);
        chk("R10", "rx_busy untouched", rx_busy, 0);
        chk("R6", "wcol", wcol, inject);
        for (int k = 0; k < r + 6; k++) @(negedge clk);
        chk("R5", "scl held low", scl_drive_low, 1);
        chk("R5", "sda left released", sda_drive_low, 0);
    endtask

    task automatic rx_byte(input logic [7:0] r, input logic [7:0] d, input logic exp_ov);
        int n;
        reload_val = r;
        @(negedge clk); rx_start = 1; slave_low = !d[7];
        @(negedge clk); rx_start = 0;
        chk("R7", "rx_busy set", rx_busy, 1);
        chk("R7", "sda released", sda_drive_low, 0);
        for (int i = 0; i < 8; i++) begin
            slave_low = !d[7-i];
            walk(1'b1, n); chk("R2", "rx low width", n, r + 1);
            walk(1'b0, n); chk("R2", "rx high width", n, r + 1);
        end
        slave_low = 0;
        chk("R8", "rx_data", rx_data, d);
        chk("R8", "buf_full", buf_full, 1);
        chk("R8", "done", done, 1);
        chk("R8", "rx_busy cleared", rx_busy, 0);
        chk("R8", "scl held low", scl_drive_low, 1);
        chk("R9", "rx_ov", rx_ov, exp_ov);
    endtask

    task automatic ack_seq(input logic [7:0] r, input logic v);
        int n;
        reload_val = r;
        pulse_clear(0);
        @(negedge clk); ack_start = 1; ack_value = v;
        @(negedge clk); ack_start = 0;
        chk("R11", "ack drive", sda_drive_low, !v);
        walk(1'b1, n); chk("R11", "ack low width", n, r + 1);
        chk("R11", "ack held in high", sda_drive_low, !v);
        walk(1'b0, n); chk("R11", "ack high width", n, r + 1);
        chk("R11", "done after ack", done, 1);
    endtask

    initial begin
        #(200000 * 5);
        n_vec++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk("R5", "reset scl", scl_drive_low, 1);
        chk("R5", "reset sda", sda_drive_low, 0);
        chk("R5", "reset flags", {buf_full, wcol, rx_ov, ack_stat, done, rx_busy}, 0);

        tx_byte(8'd3, 8'hA5, 1'b1, 1'b0);
        pulse_clear(0);
        chk("R12", "done cleared", done, 0);
        tx_byte(8'd0, 8'h3C, 1'b0, 1'b0);
        tx_byte(8'd4, 8'h96, 1'b1, 1'b1);
        pulse_clear(1);
        chk("R6", "wcol cleared", wcol, 0);

        rx_byte(8'd5, 8'h5B, 1'b0);
        ack_seq(8'd5, 1'b0);
        rx_byte(8'd2, 8'hC3, 1'b1);
        pulse_clear(3);
        chk("R9", "buf_full cleared by read", buf_full, 0);
        chk("R9", "rx_ov stays until cleared", rx_ov, 1);
        pulse_clear(2);
        chk("R9", "rx_ov cleared", rx_ov, 0);
        rx_byte(8'd1, 8'h81, 1'b0);
        pulse_clear(3);
        ack_seq(8'd1, 1'b1);
        tx_byte(8'd2, 8'h01, 1'b1, 1'b0);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule